// File: doc/BRIEF.md
# Transmit Path Failure Supervisor

This block watches the digital side of a CAN node's transmitter and decides when the transmitter must be switched off. It takes the transmit data line, the received data line, a bus-dominant indication, a bus-short sense input and an overtemperature input. It also takes the operating mode. From these it produces a transmitter enable, a local-failure flag and a bus-failure flag. All inputs are assumed to be synchronous to `clk`. On both data lines a low level means dominant.

Four local faults set the local-failure flag. Three of them also switch the transmitter off until the flag is cleared: transmit data held dominant for too long, the receive line held dominant while transmit is recessive (a transmit-to-receive short), and overtemperature. The fourth is a bus held dominant for too long. It only raises the flag, and the flag drops again as soon as the bus is recessive. A separate bus-failure flag is set when a bus short is sensed during four qualifying transmit cycles in a row. Every timeout is a parameter counted in clock cycles.

Top module: `txdiag_tx_supervisor`

## Requirements
- R1: While supervision is active, if `txd` is low for more than `TXD_TIMEOUT_CYC` consecutive cycles, then on the following edge `local_fail` goes high, `tx_en` goes low, and both are latched.
- R2: In normal mode with the transmitter enabled, if `txd` is high and `rxd` is low for more than `BUS_TIMEOUT_CYC` consecutive cycles, a transmit-to-receive short is latched. This sets `local_fail` and drops `tx_en`.
- R3: While supervision is active, one sampled cycle with `over_temp` high latches an overtemperature fault. This sets `local_fail` and drops `tx_en`.
- R4: A latched fault holds until a clear event. `tx_en` is high only when `mode` is normal (2'b10) and no fault is latched.
- R5: While supervision is active, if `bus_dom` is high for more than `BUS_TIMEOUT_CYC` consecutive cycles, `local_fail` is set but `tx_en` is left alone. This indication drops one edge after `bus_dom` goes low.
- R6: Latched faults clear on reset, on entry into normal mode, or when `rxd` is low while `txd` is high in an active mode. Such a clear happens only if, in that cycle, `txd` is high, `over_temp` is low and no bus-clamp indication is present. A new fault raised in the same cycle wins over the clear.
- R7: Supervision is active only in listen mode (2'b01) and normal mode (2'b10). In standby (2'b00) and sleep (2'b11), no fault is raised and latched faults keep their state.
- R8: `bus_fail` is set at the dominant-to-recessive `txd` edge that completes four consecutive qualifying dominant phases, each driven with `tx_en` high and with `bus_short` seen in at least one of its cycles. A qualifying phase without `bus_short` restarts the count.
- R9: A dominant phase shorter than `MIN_DOM_CYC` cycles does not qualify. It leaves the consecutive count unchanged.
- R10: `bus_fail` is cleared only by reset or by entry into normal mode. It holds while the block sits in other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| txd | input | 1 | Transmit data from the protocol controller, low = dominant |
| rxd | input | 1 | Receive data line toward the controller, low = dominant |
| bus_dom | input | 1 | Bus differential receiver reports dominant |
| bus_short | input | 1 | Analog sense reports a bus line short while driving |
| over_temp | input | 1 | Junction overtemperature indication |
| mode | input | 2 | 00 standby, 01 listen, 10 normal, 11 sleep |
| tx_en | output | 1 | Transmitter driver enable |
| local_fail | output | 1 | Local failure flag, high = set |
| bus_fail | output | 1 | Bus failure flag, high = set |

## Verification
The bench probes each timeout exactly one cycle short of expiry and then exactly at it. An off-by-one counter would show up as the flag rising one edge early or one edge late. It checks that a bus clamp leaves `tx_en` high and drops the flag on the first recessive cycle; a design that latched the clamp would keep the flag up. It tries to clear an overtemperature fault by re-entering normal mode while the temperature is still high, which a design that ignored the resolved condition would let through. On the bus-failure path it runs a streak broken by a short-free phase and a streak interrupted by a too-short phase. These catch a design that counts instead of requiring consecutive phases, and one that lets runt phases reset or advance the count.

// File: rtl/txdiag_pkg.sv
// Shared types for the transmit path supervisor.
// Assumes the mode code is supplied by an upstream mode controller.
package txdiag_pkg;

    typedef enum logic [1:0] {
        MODE_STBY   = 2'b00,
        MODE_LISTEN = 2'b01,
        MODE_NORMAL = 2'b10,
        MODE_SLEEP  = 2'b11
    } op_mode_e;

    localparam int NUM_TIMERS = 3;
    localparam int TMR_TXD    = 0;
    localparam int TMR_SHORT  = 1;
    localparam int TMR_BUS    = 2;

    // Failure supervision runs only in the two bus-connected modes.
    function automatic logic mode_supervised(input op_mode_e m);
        return (m == MODE_LISTEN) || (m == MODE_NORMAL);
    endfunction

endpackage

// File: rtl/txdiag_run_timer.sv
// Run-length timer: counts consecutive cycles with run high, saturating.
// expired is high in a cycle where run is high and run was also high
// for the LIMIT cycles before it. Assumes LIMIT >= 1.
module txdiag_run_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int            CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count the current run of high samples, cleared by any low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIM);

endmodule

// File: rtl/txdiag_local_fail.sv
// Local failure latch and clear logic.
// Holds three latched causes (transmit clamp, transmit-to-receive short,
// overtemperature) plus a self-releasing bus clamp indication.
// Assumes the timer expiries already carry the mode gating.
module txdiag_local_fail (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic norm_entry,
    input  logic txd,
    input  logic rxd,
    input  logic over_temp,
    input  logic txd_exp,
    input  logic short_exp,
    input  logic bus_exp,
    output logic tx_block,
    output logic local_fail
);
    logic lat_txd, lat_short, lat_ot, clamp_q;
    logic clear_req, resolved, clear_ok, ot_set;

    // A clear is requested on normal entry or by dominant receive with recessive transmit.
    assign clear_req = norm_entry || (active && txd && !rxd);
    assign resolved  = txd && !over_temp && !clamp_q;
    assign clear_ok  = clear_req && resolved;
    assign ot_set    = active && over_temp;

    // Latched causes: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_txd   <= 1'b0;
            lat_short <= 1'b0;
            lat_ot    <= 1'b0;
        end else begin
            lat_txd   <= txd_exp   ? 1'b1 : (clear_ok ? 1'b0 : lat_txd);
            lat_short <= short_exp ? 1'b1 : (clear_ok ? 1'b0 : lat_short);
            lat_ot    <= ot_set    ? 1'b1 : (clear_ok ? 1'b0 : lat_ot);
        end
    end

    // Bus clamp indication follows the bus timer and is never latched.
    always_ff @(posedge clk) begin
        if (!rst_n) clamp_q <= 1'b0;
        else        clamp_q <= bus_exp;
    end

    assign tx_block   = lat_txd || lat_short || lat_ot;
    assign local_fail = tx_block || clamp_q;

    a_r1_clamp_latches: assert property (@(posedge clk) disable iff (!rst_n)
        txd_exp |=> (tx_block && local_fail));

    a_r6_clear_needs_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_block) |-> ($past(txd) && !$past(over_temp)));

    a_r7_inactive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(tx_block));

endmodule

// File: rtl/txdiag_bus_fail.sv
// Bus failure monitor: judges each dominant-to-recessive transmit phase
// while driving and sets the flag after CYCLES consecutive phases with a
// sensed short. Phases shorter than MIN_DOM cycles are not judged.
// Assumes drive_en is the live transmitter enable.
module txdiag_bus_fail #(
    parameter int MIN_DOM = 4,
    parameter int CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic txd,
    input  logic bus_short,
    input  logic norm_entry,
    output logic bus_fail
);
    localparam int            DW    = $clog2(MIN_DOM + 1);
    localparam int            SW    = $clog2(CYCLES + 1);
    localparam logic [DW-1:0] DMAX  = DW'(MIN_DOM);
    localparam logic [SW-1:0] SMAX  = SW'(CYCLES);
    localparam logic [SW-1:0] SLAST = SW'(CYCLES - 1);

    logic          txd_q, seen, long_enough, rec_edge, fire;
    logic [DW-1:0] dom_len;
    logic [SW-1:0] streak;

    assign long_enough = (dom_len == DMAX);
    assign rec_edge    = drive_en && txd && !txd_q;
    assign fire        = rec_edge && long_enough && seen && (streak >= SLAST);

    // Previous transmit level for edge detection, tracked in every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd;
    end

    // Dominant phase length, short observation and consecutive phase count.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive_en) begin
            dom_len <= '0;
            seen    <= 1'b0;
            streak  <= '0;
        end else if (!txd) begin
            if (!long_enough) dom_len <= dom_len + 1'b1;
            seen <= seen || bus_short;
        end else if (!txd_q) begin
            dom_len <= '0;
            seen    <= 1'b0;
            if (long_enough) begin
                if (!seen)              streak <= '0;
                else if (streak != SMAX) streak <= streak + 1'b1;
            end
        end
    end

    // Flag: set on the completing edge, cleared only on normal entry or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          bus_fail <= 1'b0;
        else if (norm_entry) bus_fail <= 1'b0;
        else if (fire)       bus_fail <= 1'b1;
    end

    a_r8_fail_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fail) |-> $past(drive_en));

    a_r9_runt_phase_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_edge && !long_enough) |=> $stable(streak));

    a_r10_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        norm_entry |=> !bus_fail);

endmodule

// File: rtl/txdiag_tx_supervisor.sv
// Transmit path failure supervisor (top).
// Combines three run-length timers, the local failure latch and the bus
// failure monitor. Assumes all inputs are synchronous to clk and that low
// on txd/rxd means dominant.
module txdiag_tx_supervisor
    import txdiag_pkg::*;
#(
    parameter int TXD_TIMEOUT_CYC = 150000,
    parameter int BUS_TIMEOUT_CYC = 150000,
    parameter int MIN_DOM_CYC     = 400,
    parameter int FAIL_CYCLES     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd,
    input  logic       rxd,
    input  logic       bus_dom,
    input  logic       bus_short,
    input  logic       over_temp,
    input  logic [1:0] mode,
    output logic       tx_en,
    output logic       local_fail,
    output logic       bus_fail
);
    op_mode_e                mode_e, mode_q;
    logic                    active, norm_entry, tx_block;
    logic [NUM_TIMERS-1:0]   tmr_run, tmr_exp;

    assign mode_e     = op_mode_e'(mode);
    assign active     = mode_supervised(mode_e);
    assign norm_entry = (mode_e == MODE_NORMAL) && (mode_q != MODE_NORMAL);
    assign tx_en      = (mode_e == MODE_NORMAL) && !tx_block;

    // Previous mode, used to detect entry into normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_STBY;
        else        mode_q <= mode_e;
    end

    assign tmr_run[TMR_TXD]   = active && !txd;
    assign tmr_run[TMR_SHORT] = tx_en && txd && !rxd;
    assign tmr_run[TMR_BUS]   = active && bus_dom;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        localparam int LIM = (g == TMR_TXD) ? TXD_TIMEOUT_CYC : BUS_TIMEOUT_CYC;
        txdiag_run_timer #(.LIMIT(LIM)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (tmr_run[g]),
            .expired (tmr_exp[g])
        );
    end

    txdiag_local_fail u_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .norm_entry (norm_entry),
        .txd        (txd),
        .rxd        (rxd),
        .over_temp  (over_temp),
        .txd_exp    (tmr_exp[TMR_TXD]),
        .short_exp  (tmr_exp[TMR_SHORT]),
        .bus_exp    (tmr_exp[TMR_BUS]),
        .tx_block   (tx_block),
        .local_fail (local_fail)
    );

    txdiag_bus_fail #(.MIN_DOM(MIN_DOM_CYC), .CYCLES(FAIL_CYCLES)) u_busf (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en   (tx_en),
        .txd        (txd),
        .bus_short  (bus_short),
        .norm_entry (norm_entry),
        .bus_fail   (bus_fail)
    );

    a_r5_clamp_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_dom && !tx_block && !tmr_exp[TMR_TXD] && !tmr_exp[TMR_SHORT]
         && !(active && over_temp)) |=> !local_fail);

    a_r4_block_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_block && !tmr_exp[TMR_TXD] && !tmr_exp[TMR_SHORT]
         && !(active && over_temp)) |=> !tx_block);

endmodule

// File: tb/txdiag_tx_supervisor_test.sv
`timescale 1ns/1ps
module txdiag_tx_supervisor_test;
    localparam int TT = 20;
    localparam int BT = 12;
    localparam int MD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, rxd = 1'b1, bus_dom = 1'b0, bshort = 1'b0, ot = 1'b0;
    logic [1:0] mode = 2'b00;
    logic tx_en, local_fail, bus_fail;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txdiag_tx_supervisor #(.TXD_TIMEOUT_CYC(TT), .BUS_TIMEOUT_CYC(BT),
                           .MIN_DOM_CYC(MD), .FAIL_CYCLES(4)) uut (
        .clk(clk), .rst_n(rst_n), .txd(txd), .rxd(rxd), .bus_dom(bus_dom),
        .bus_short(bshort), .over_temp(ot), .mode(mode),
        .tx_en(tx_en), .local_fail(local_fail), .bus_fail(bus_fail));

    // Behavioural reference model
    int  run_t, run_s, run_b, domlen, streak;
    bit  lat_t, lat_s, lat_o, m_clamp, m_bf, seen, m_txq;
    int  m_prev;

    always @(posedge clk) begin
        bit act, nrm, entry, ten, clr, st, ss, so;
        if (!rst_n) begin
            run_t = 0; run_s = 0; run_b = 0; domlen = 0; streak = 0;
            lat_t = 0; lat_s = 0; lat_o = 0; m_clamp = 0; m_bf = 0;
            seen = 0; m_txq = 1; m_prev = 0;
        end else begin
            act   = (mode == 2'b01) || (mode == 2'b10);
            nrm   = (mode == 2'b10);
            entry = nrm && (m_prev != 2);
            ten   = nrm && !(lat_t || lat_s || lat_o);
            run_t = (act && !txd) ? run_t + 1 : 0;
            run_s = (ten && txd && !rxd) ? run_s + 1 : 0;
            run_b = (act && bus_dom) ? run_b + 1 : 0;
            st = run_t > TT; ss = run_s > BT; so = act && ot;
            clr = (entry || (act && txd && !rxd)) && txd && !ot && !m_clamp;
            lat_t = st ? 1'b1 : (clr ? 1'b0 : lat_t);
            lat_s = ss ? 1'b1 : (clr ? 1'b0 : lat_s);
            lat_o = so ? 1'b1 : (clr ? 1'b0 : lat_o);
            m_clamp = run_b > BT;
            if (entry) m_bf = 0;
            if (!ten) begin
                domlen = 0; seen = 0; streak = 0;
            end else if (!txd) begin
                domlen++; seen = seen || bshort;
            end else if (!m_txq) begin
                if (domlen >= MD) begin
                    if (seen) begin
                        streak++;
                        if (streak >= 4) m_bf = 1;
                    end else streak = 0;
                end
                domlen = 0; seen = 0;
            end
            m_txq = txd;
            m_prev = int'(mode);
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Compare all outputs against the model, then return (inputs change after)
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, "tx_en", int'(tx_en), int'(mode == 2'b10 && !(lat_t || lat_s || lat_o)));
            chk(tag, "local_fail", int'(local_fail), int'(lat_t || lat_s || lat_o || m_clamp));
            chk(tag, "bus_fail", int'(bus_fail), int'(m_bf));
        end
    endtask

    task automatic expect3(input string tag, input int e_en, input int e_lf, input int e_bf);
        chk(tag, "tx_en", int'(tx_en), e_en);
        chk(tag, "local_fail", int'(local_fail), e_lf);
        chk(tag, "bus_fail", int'(bus_fail), e_bf);
    endtask

    task automatic pulse(input int len, input bit sh);
        txd = 1'b0; bshort = sh;
        run(len, "R8");
        txd = 1'b1; bshort = 1'b0;
        run(3, "R8");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(1, "R7");
        expect3("R7", 0, 0, 0);                 // reset state, standby
        mode = 2'b10; run(2, "R4");
        expect3("R4", 1, 0, 0);

        // R1: transmit dominant timeout
        txd = 1'b0; run(15, "R1"); txd = 1'b1; run(2, "R1");
        expect3("R1", 1, 0, 0);
        txd = 1'b0; run(TT, "R1");
        expect3("R1", 1, 0, 0);
        run(1, "R1");
        expect3("R1", 0, 1, 0);
        txd = 1'b1; run(5, "R4");
        expect3("R4", 0, 1, 0);
        mode = 2'b00; run(2, "R6"); mode = 2'b10; run(1, "R6");
        expect3("R6", 1, 0, 0);

        // R5: bus clamp, transmitter stays enabled, self-releasing
        txd = 1'b0; rxd = 1'b0; bus_dom = 1'b1; run(BT, "R5");
        expect3("R5", 1, 0, 0);
        run(1, "R5");
        expect3("R5", 1, 1, 0);
        txd = 1'b1; rxd = 1'b1; bus_dom = 1'b0; run(1, "R5");
        expect3("R5", 1, 0, 0);

        // R2: transmit-to-receive short
        rxd = 1'b0; run(BT, "R2");
        expect3("R2", 1, 0, 0);
        run(1, "R2");
        expect3("R2", 0, 1, 0);
        rxd = 1'b1; run(3, "R4");
        expect3("R4", 0, 1, 0);
        rxd = 1'b0; run(1, "R6");
        expect3("R6", 1, 0, 0);
        rxd = 1'b1; run(1, "R6");

        // R3: overtemperature, clear blocked while still hot
        ot = 1'b1; run(1, "R3");
        expect3("R3", 0, 1, 0);
        mode = 2'b00; run(2, "R6"); mode = 2'b10; run(1, "R6");
        expect3("R6", 0, 1, 0);
        ot = 1'b0; run(2, "R4");
        expect3("R4", 0, 1, 0);
        rxd = 1'b0; run(1, "R6");
        expect3("R6", 1, 0, 0);
        rxd = 1'b1; run(1, "R6");

        // R7: no detection in standby or sleep
        mode = 2'b00; txd = 1'b0; ot = 1'b1; bus_dom = 1'b1; run(30, "R7");
        expect3("R7", 0, 0, 0);
        mode = 2'b11; run(5, "R7");
        expect3("R7", 0, 0, 0);
        txd = 1'b1; ot = 1'b0; bus_dom = 1'b0; run(2, "R7");
        mode = 2'b10; run(2, "R7");
        expect3("R7", 1, 0, 0);

        // R8/R9: bus failure over consecutive phases
        pulse(5, 1); pulse(5, 1); pulse(5, 1);
        expect3("R8", 1, 0, 0);
        pulse(5, 0);
        pulse(5, 1); pulse(5, 1); pulse(5, 1);
        expect3("R8", 1, 0, 0);
        pulse(2, 0);
        expect3("R9", 1, 0, 0);
        pulse(5, 1);
        expect3("R9", 1, 0, 1);

        // R10: held outside normal, cleared on normal entry
        mode = 2'b01; run(3, "R10");
        expect3("R10", 0, 0, 1);
        mode = 2'b10; run(1, "R10");
        expect3("R10", 1, 0, 0);
        run(3, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule